// File: doc/BRIEF.md
# Template Pair Hot/Cold Evaluator

This block scores one pair of sampling templates at one pixel position. It takes in sixty pixel values, thirty from a background template and thirty from a target template. Each value arrives on a valid-qualified stream with a tag that says which template it belongs to. Both sets are stored locally while the background total builds up. Once both sets are complete, the block walks the two stores side by side. It sorts each value into "hot" or "cold" against the background average of the same window and adds it to one of four running totals.

The adaptive threshold is the average of the thirty background samples. It is never divided out. A sample v is hot exactly when thirty times v exceeds the background total, which matches a comparison against the unrounded average. A start pulse opens a new evaluation and zeroes every total. A one-cycle done strobe marks the moment the four totals are final. The totals then stay on the outputs until the next start. Fetching the samples, the correlation that uses the four totals and the final threshold decision are handled outside.

Top module: `hotcold_pair_eval`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, done_o is 0 and all four totals read 0.
- R2: A cycle with start_i high clears the four totals and opens a collection phase. On the cycle after the start, all totals read 0 and done_o is 0. A start during collection discards the samples gathered so far.
- R3: During collection, a sample with smp_valid_i high is stored as background when smp_is_tgt_i is 0 and as target when it is 1. Background and target samples may arrive in any order or interleaving. Once thirty samples of a class are held, further samples of that class are ignored.
- R4: A background sample v counts as hot when 30*v is greater than the sum of the thirty background samples, and as cold otherwise. bg_hot_o and bg_cold_o are the sums of the hot and the cold background samples.
- R5: A target sample is classified by the same rule against the same background sum. tgt_hot_o and tgt_cold_o are the sums of the hot and the cold target samples.
- R6: A sample exactly equal to the background average is cold. So when every background sample is equal, bg_hot_o is 0 and bg_cold_o is the full background sum.
- R7: done_o is high for exactly one cycle. It rises at the 31st rising edge after the edge that accepts the last of the sixty samples, and the four totals are final in that same cycle.
- R8: Samples presented while no collection is open, including during classification and after done_o, have no effect. The totals hold their values until the next start.
- R9: Each total is 10 bits wide and holds the extreme cases without wrapping: thirty samples of 31 give 930.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that opens a new evaluation |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_is_tgt_i | input | 1 | Sample class: 0 background, 1 target |
| smp_data_i | input | 5 | Pixel value of the sample |
| done_o | output | 1 | One-cycle strobe: totals are final |
| bg_hot_o | output | 10 | Sum of background samples above the average |
| bg_cold_o | output | 10 | Sum of background samples at or below the average |
| tgt_hot_o | output | 10 | Sum of target samples above the background average |
| tgt_cold_o | output | 10 | Sum of target samples at or below the background average |

## Verification
The assertions assume that start_i is a single-cycle pulse and that the input stream is meaningful only between a start and the completion of both sample sets. They also assume the totals are read only around done_o. The bench drives every input on the falling clock edge and issues start only from an idle or collecting state. Outside collection it deliberately sends extra samples, surplus samples of a full class and junk during classification, to show that those are dropped rather than to violate any assumption.

// File: rtl/hcpe_pkg.sv
package hcpe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_SCAN    = 2'd2
  } phase_e;

  // Hot test without a divider: v > total/n  <=>  n*v > total
  function automatic logic is_hot(input logic [31:0] val,
                                  input logic [31:0] total,
                                  input int unsigned n_pts);
    return (val * n_pts) > total;
  endfunction

  // Add a pixel value into a wider accumulator
  function automatic logic [31:0] acc_add(input logic [31:0] acc,
                                          input logic [31:0] val);
    return acc + val;
  endfunction

endpackage

// File: rtl/hcpe_buf.sv
module hcpe_buf #(
  parameter int W     = 5,
  parameter int DEPTH = 30,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    if (32'(rd_addr) < DEPTH) rd_data = mem[rd_addr];
    else                      rd_data = '0;
  end

endmodule

// File: rtl/hcpe_ctrl.sv
module hcpe_ctrl
  import hcpe_pkg::*;
#(
  parameter int PIX_W = 5,
  parameter int N_PTS = 30,
  parameter int IDX_W = 5,
  parameter int CNT_W = 5,
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic             smp_is_tgt_i,
  input  logic [PIX_W-1:0] smp_data_i,
  output logic             bg_wr_o,
  output logic             tgt_wr_o,
  output logic [IDX_W-1:0] bg_waddr_o,
  output logic [IDX_W-1:0] tgt_waddr_o,
  output logic             scan_en_o,
  output logic             scan_last_o,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic [CNT_W-1:0] bg_cnt_o,
  output logic [CNT_W-1:0] tgt_cnt_o,
  output logic [SUM_W-1:0] bg_total_o,
  output logic [SUM_W-1:0] tgt_total_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_PTS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PTS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] bg_cnt_q, tgt_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [SUM_W-1:0] bg_total_q, tgt_total_q;
  logic             done_q;
  logic             collecting;
  logic             all_in;

  assign collecting = (phase_q == PH_COLLECT) && !start_i;
  assign all_in     = (bg_cnt_q == FULL) && (tgt_cnt_q == FULL);

  assign bg_wr_o  = collecting && smp_valid_i && !smp_is_tgt_i && (bg_cnt_q < FULL);
  assign tgt_wr_o = collecting && smp_valid_i &&  smp_is_tgt_i && (tgt_cnt_q < FULL);

  assign bg_waddr_o  = IDX_W'(bg_cnt_q);
  assign tgt_waddr_o = IDX_W'(tgt_cnt_q);

  assign scan_en_o   = (phase_q == PH_SCAN) && !start_i;
  assign scan_last_o = (idx_q == LAST);
  assign scan_idx_o  = idx_q;

  assign bg_cnt_o    = bg_cnt_q;
  assign tgt_cnt_o   = tgt_cnt_q;
  assign bg_total_o  = bg_total_q;
  assign tgt_total_o = tgt_total_q;
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      bg_cnt_q    <= '0;
      tgt_cnt_q   <= '0;
      idx_q       <= '0;
      bg_total_q  <= '0;
      tgt_total_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        phase_q     <= PH_COLLECT;
        bg_cnt_q    <= '0;
        tgt_cnt_q   <= '0;
        idx_q       <= '0;
        bg_total_q  <= '0;
        tgt_total_q <= '0;
      end else begin
        unique case (phase_q)
          PH_COLLECT: begin
            if (bg_wr_o) begin
              bg_cnt_q   <= bg_cnt_q + 1'b1;
              bg_total_q <= SUM_W'(acc_add(32'(bg_total_q), 32'(smp_data_i)));
            end
            if (tgt_wr_o) begin
              tgt_cnt_q   <= tgt_cnt_q + 1'b1;
              tgt_total_q <= SUM_W'(acc_add(32'(tgt_total_q), 32'(smp_data_i)));
            end
            if (all_in) begin
              phase_q <= PH_SCAN;
              idx_q   <= '0;
            end
          end
          PH_SCAN: begin
            idx_q <= idx_q + 1'b1;
            if (scan_last_o) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/hcpe_acc.sv
module hcpe_acc
  import hcpe_pkg::*;
#(
  parameter int PIX_W = 5,
  parameter int N_PTS = 30,
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             scan_en_i,
  input  logic [PIX_W-1:0] val_i,
  input  logic [SUM_W-1:0] ref_total_i,
  output logic             hot_o,
  output logic [SUM_W-1:0] hot_sum_o,
  output logic [SUM_W-1:0] cold_sum_o
);

  logic [SUM_W-1:0] hot_q, cold_q;

  assign hot_o = is_hot(32'(val_i), 32'(ref_total_i), N_PTS);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      hot_q  <= '0;
      cold_q <= '0;
    end else if (scan_en_i) begin
      if (hot_o) hot_q  <= SUM_W'(acc_add(32'(hot_q), 32'(val_i)));
      else       cold_q <= SUM_W'(acc_add(32'(cold_q), 32'(val_i)));
    end
  end

  assign hot_sum_o  = hot_q;
  assign cold_sum_o = cold_q;

endmodule

// File: rtl/hotcold_pair_eval.sv
module hotcold_pair_eval #(
  parameter int PIX_W = 5,
  parameter int N_PTS = 30,
  localparam int IDX_W = $clog2(N_PTS),
  localparam int CNT_W = $clog2(N_PTS + 1),
  localparam int SUM_W = PIX_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic             smp_is_tgt_i,
  input  logic [PIX_W-1:0] smp_data_i,
  output logic             done_o,
  output logic [SUM_W-1:0] bg_hot_o,
  output logic [SUM_W-1:0] bg_cold_o,
  output logic [SUM_W-1:0] tgt_hot_o,
  output logic [SUM_W-1:0] tgt_cold_o
);

  localparam int N_CLS = 2;  // class 0 background, class 1 target

  logic             bg_wr, tgt_wr;
  logic [IDX_W-1:0] bg_waddr, tgt_waddr;
  logic             scan_en, scan_last;
  logic [IDX_W-1:0] scan_idx;
  logic [CNT_W-1:0] bg_cnt, tgt_cnt;
  logic [SUM_W-1:0] bg_total, tgt_total;

  logic [N_CLS-1:0]            cls_wr;
  logic [N_CLS-1:0][IDX_W-1:0] cls_waddr;
  logic [N_CLS-1:0]            cls_hot;
  logic [N_CLS-1:0][SUM_W-1:0] cls_hot_sum;
  logic [N_CLS-1:0][SUM_W-1:0] cls_cold_sum;

  assign cls_wr[0]    = bg_wr;
  assign cls_wr[1]    = tgt_wr;
  assign cls_waddr[0] = bg_waddr;
  assign cls_waddr[1] = tgt_waddr;

  hcpe_ctrl #(
    .PIX_W(PIX_W), .N_PTS(N_PTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .smp_valid_i (smp_valid_i),
    .smp_is_tgt_i(smp_is_tgt_i),
    .smp_data_i  (smp_data_i),
    .bg_wr_o     (bg_wr),
    .tgt_wr_o    (tgt_wr),
    .bg_waddr_o  (bg_waddr),
    .tgt_waddr_o (tgt_waddr),
    .scan_en_o   (scan_en),
    .scan_last_o (scan_last),
    .scan_idx_o  (scan_idx),
    .bg_cnt_o    (bg_cnt),
    .tgt_cnt_o   (tgt_cnt),
    .bg_total_o  (bg_total),
    .tgt_total_o (tgt_total),
    .done_o      (done_o)
  );

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    logic [PIX_W-1:0] rd_val;
    logic             hot;
    logic [SUM_W-1:0] hot_sum, cold_sum;

    hcpe_buf #(.W(PIX_W), .DEPTH(N_PTS), .AW(IDX_W)) u_buf (
      .clk    (clk),
      .wr_en  (cls_wr[c]),
      .wr_addr(cls_waddr[c]),
      .wr_data(smp_data_i),
      .rd_addr(scan_idx),
      .rd_data(rd_val)
    );

    hcpe_acc #(.PIX_W(PIX_W), .N_PTS(N_PTS), .SUM_W(SUM_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (start_i),
      .scan_en_i  (scan_en),
      .val_i      (rd_val),
      .ref_total_i(bg_total),
      .hot_o      (hot),
      .hot_sum_o  (hot_sum),
      .cold_sum_o (cold_sum)
    );

    assign cls_hot[c]      = hot;
    assign cls_hot_sum[c]  = hot_sum;
    assign cls_cold_sum[c] = cold_sum;
  end

  assign bg_hot_o   = cls_hot_sum[0];
  assign bg_cold_o  = cls_cold_sum[0];
  assign tgt_hot_o  = cls_hot_sum[1];
  assign tgt_cold_o = cls_cold_sum[1];

endmodule

// File: rtl/hotcold_pair_eval_chk.sv
module hotcold_pair_eval_chk #(
  parameter int N_PTS = 30,
  parameter int CNT_W = 5,
  parameter int SUM_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             scan_en,
  input logic [CNT_W-1:0] bg_cnt,
  input logic [CNT_W-1:0] tgt_cnt,
  input logic [SUM_W-1:0] bg_total,
  input logic [SUM_W-1:0] tgt_total,
  input logic [SUM_W-1:0] bg_hot_o,
  input logic [SUM_W-1:0] bg_cold_o,
  input logic [SUM_W-1:0] tgt_hot_o,
  input logic [SUM_W-1:0] tgt_cold_o
);

  // R1: nothing reported straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!done_o && bg_hot_o == '0 && tgt_hot_o == '0));

  // R2: start zeroes the totals by the next cycle
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (bg_hot_o == '0 && bg_cold_o == '0 &&
                 tgt_hot_o == '0 && tgt_cold_o == '0 && !done_o));

  // R3: a class never holds more than its template size
  a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bg_cnt) <= N_PTS) && (32'(tgt_cnt) <= N_PTS));

  // R4: background split covers the whole background sum
  a_r4_bg_split: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((SUM_W+1)'(bg_hot_o) + (SUM_W+1)'(bg_cold_o) == (SUM_W+1)'(bg_total)));

  // R5: target split covers the whole target sum
  a_r5_tgt_split: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((SUM_W+1)'(tgt_hot_o) + (SUM_W+1)'(tgt_cold_o) == (SUM_W+1)'(tgt_total)));

  // R7: done is a single-cycle strobe that follows a classification step
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(scan_en));

  // R8: totals are frozen outside classification
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !scan_en) |=> ($stable(bg_hot_o) && $stable(bg_cold_o) &&
                                $stable(tgt_hot_o) && $stable(tgt_cold_o)));

endmodule

bind hotcold_pair_eval hotcold_pair_eval_chk #(
  .N_PTS(N_PTS), .CNT_W(CNT_W), .SUM_W(SUM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .done_o    (done_o),
  .scan_en   (scan_en),
  .bg_cnt    (bg_cnt),
  .tgt_cnt   (tgt_cnt),
  .bg_total  (bg_total),
  .tgt_total (tgt_total),
  .bg_hot_o  (bg_hot_o),
  .bg_cold_o (bg_cold_o),
  .tgt_hot_o (tgt_hot_o),
  .tgt_cold_o(tgt_cold_o)
);

// File: tb/hotcold_pair_eval_test.sv
module hotcold_pair_eval_test;

  localparam int NP = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       smp_valid_i = 1'b0;
  logic       smp_is_tgt_i = 1'b0;
  logic [4:0] smp_data_i = '0;
  logic       done_o;
  logic [9:0] bg_hot_o, bg_cold_o, tgt_hot_o, tgt_cold_o;

  hotcold_pair_eval uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_is_tgt_i(smp_is_tgt_i), .smp_data_i(smp_data_i), .done_o(done_o),
    .bg_hot_o(bg_hot_o), .bg_cold_o(bg_cold_o),
    .tgt_hot_o(tgt_hot_o), .tgt_cold_o(tgt_cold_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    bh, bc, th, tc;
    string lbl;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_tests = 0;
  int   n_fail  = 0;
  int   bgv[NP];
  int   tgv[NP];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: hot when strictly above the integer part of the average
  function automatic exp_t model(input string lbl);
    exp_t e;
    int   tot = 0;
    int   avg;
    e.bh = 0; e.bc = 0; e.th = 0; e.tc = 0; e.lbl = lbl;
    for (int i = 0; i < NP; i++) tot += bgv[i];
    avg = tot / NP;
    for (int i = 0; i < NP; i++) begin
      if (bgv[i] > avg) e.bh += bgv[i]; else e.bc += bgv[i];
      if (tgv[i] > avg) e.th += tgv[i]; else e.tc += tgv[i];
    end
    return e;
  endfunction

  task automatic send(input bit tgt, input int v);
    smp_valid_i  = 1'b1;
    smp_is_tgt_i = tgt;
    smp_data_i   = 5'(v);
    @(negedge clk);
  endtask

  task automatic do_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2", "bg_hot after start", int'(bg_hot_o), 0);
    check("R2", "tgt_cold after start", int'(tgt_cold_o), 0);
    check("R2", "done after start", int'(done_o), 0);
  endtask

  // order 0: background first, 1: target first, 2: interleaved
  task automatic run_eval(input int order, input bit noise, input string lbl);
    exp_t e;
    e = model(lbl);
    exp_q.push_back(e);
    last_exp = e;
    do_start();
    if (order == 0) begin
      for (int i = 0; i < NP; i++) send(1'b0, bgv[i]);
      if (noise) begin
        send(1'b0, 31);  // R3: surplus background, must be dropped
        send(1'b0, 31);
      end
      for (int i = 0; i < NP; i++) send(1'b1, tgv[i]);
    end else if (order == 1) begin
      for (int i = 0; i < NP; i++) send(1'b1, tgv[i]);
      if (noise) send(1'b1, 0);  // R3: surplus target
      for (int i = 0; i < NP; i++) send(1'b0, bgv[i]);
    end else begin
      for (int i = 0; i < NP; i++) begin
        send(1'b0, bgv[i]);
        send(1'b1, tgv[i]);
      end
    end
    smp_valid_i = 1'b0;
    // R7 latency: done rises 31 edges after the last accepted sample
    for (int k = 1; k <= 31; k++) begin
      if (noise) begin
        smp_valid_i  = 1'b1;  // R8: junk during classification
        smp_is_tgt_i = k[0];
        smp_data_i   = 5'(k);
      end
      @(negedge clk);
      if (k < 31) begin
        if (done_o) check("R7", {lbl, " early done"}, int'(done_o), 0);
      end else begin
        check("R7", {lbl, " done at edge 31"}, int'(done_o), 1);
      end
    end
    smp_valid_i = 1'b0;
    @(negedge clk);
    check("R7", {lbl, " done single cycle"}, int'(done_o), 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R8 unexpected done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R4", {e.lbl, " bg_hot"},  int'(bg_hot_o),  e.bh);
        check("R4", {e.lbl, " bg_cold"}, int'(bg_cold_o), e.bc);
        check("R5", {e.lbl, " tgt_hot"}, int'(tgt_hot_o), e.th);
        check("R5", {e.lbl, " tgt_cold"}, int'(tgt_cold_o), e.tc);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1", "done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "bg_hot after reset", int'(bg_hot_o), 0);
    check("R1", "bg_cold after reset", int'(bg_cold_o), 0);
    check("R1", "tgt_hot after reset", int'(tgt_hot_o), 0);
    check("R1", "tgt_cold after reset", int'(tgt_cold_o), 0);

    // Ramp background (average 14.5), scattered target
    for (int i = 0; i < NP; i++) begin bgv[i] = i; tgv[i] = (i * 7) % 32; end
    run_eval(0, 1'b1, "R3_ramp");

    // R6: flat background, values equal to the average are cold
    for (int i = 0; i < NP; i++) begin bgv[i] = 17; tgv[i] = 10 + (i % 12); end
    run_eval(1, 1'b1, "R6_flat");
    check("R6", "flat bg_hot", int'(bg_hot_o), 0);
    check("R6", "flat bg_cold", int'(bg_cold_o), 510);

    // R9: all at maximum, everything cold
    for (int i = 0; i < NP; i++) begin bgv[i] = 31; tgv[i] = 31; end
    run_eval(2, 1'b0, "R9_max");
    check("R9", "max bg_cold", int'(bg_cold_o), 930);
    check("R9", "max tgt_cold", int'(tgt_cold_o), 930);

    // R9: dark background, bright target, all target hot
    for (int i = 0; i < NP; i++) begin bgv[i] = 0; tgv[i] = 31; end
    run_eval(2, 1'b1, "R9_dark");
    check("R9", "dark tgt_hot", int'(tgt_hot_o), 930);

    // R2: a start mid-collection discards earlier samples
    do_start();
    for (int i = 0; i < 10; i++) send(1'b0, 31);
    for (int i = 0; i < 5; i++) send(1'b1, 3);
    smp_valid_i = 1'b0;
    for (int i = 0; i < NP; i++) begin bgv[i] = (i * 11) % 32; tgv[i] = (i * 5 + 3) % 32; end
    run_eval(0, 1'b0, "R2_restart");

    // Pseudo-random windows in every order
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < NP; i++) begin
        bgv[i] = int'($urandom_range(31, 0));
        tgv[i] = int'($urandom_range(31, 0));
      end
      run_eval(r % 3, r[0], "R5_rand");
    end

    // R8: samples after done are ignored, totals hold
    for (int i = 0; i < 5; i++) send(i[0], 31);
    smp_valid_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R8", "held bg_hot", int'(bg_hot_o), last_exp.bh);
    check("R8", "held bg_cold", int'(bg_cold_o), last_exp.bc);
    check("R8", "held tgt_hot", int'(tgt_hot_o), last_exp.th);
    check("R8", "held tgt_cold", int'(tgt_cold_o), last_exp.tc);
    check("R8", "pending results", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule